// File: doc/BRIEF.md
# Processor single-step controller driven by the ready line

This block lets an operator freeze an 8-bit processor and walk it forward one bus cycle or one whole instruction at a time. The processor clock is never touched. It keeps running at full rate, and the controller only drives the processor's ready input. When ready is low on a read cycle, the processor repeats that cycle until ready returns high. This matters for older processors that hold state in dynamic storage: that storage is lost if the clock is slowed to a crawl.

The operator controls the block with three inputs:
- a run/step switch;
- a granularity switch that selects cycle or instruction stepping;
- a raw push-button.

The button passes through a synchroniser and a debouncer. It produces at most one step request per press. In instruction stepping, the block lets operand and data cycles through and stops only after a cycle in which the opcode-fetch marker is high. Ready is registered and changes only at the clock edge that closes a bus cycle.

Top module: `step_rdy_ctrl`

## Requirements
- R1: With the run/step switch high (run), `rdy_o` is high on every cycle after the first clock edge at which the switch was seen high.
- R2: `halted_o` is always the inverse of `rdy_o`.
- R3: In step mode with cycle granularity (`instr_mode_i` = 0), a released `rdy_o` drops at the edge ending the next read cycle, so each press lets exactly one read cycle complete.
- R4: In step mode with instruction granularity (`instr_mode_i` = 1), `rdy_o` stays high through cycles with `sync_i` low and drops at the edge ending a read cycle with `sync_i` high.
- R5: A halt that falls due on a write cycle (`rw_i` = 0) is held pending. `rdy_o` stays high and drops at the edge ending the next read cycle (`rw_i` = 1).
- R6: While reset is asserted, `rdy_o` is high. After reset in step mode, the block behaves as in instruction granularity until the first `sync_i` read cycle and halts there, whatever the granularity switch says.
- R7: The step button passes through a two-stage synchroniser and must hold a new level for `DEBOUNCE_CYCLES` consecutive clocks before it counts. A shorter pulse releases nothing.
- R8: One press releases one step. Holding the button releases nothing further, and the next step needs a release followed by a new press.
- R9: A press that completes while `rdy_o` is high is discarded. It neither changes `rdy_o` nor releases a later halt.
- R10: Mode changes take effect at the next clock edge. Going to run raises `rdy_o` there, and going to step with cycle granularity on a read cycle lowers it there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock, free-running |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Opcode-fetch marker from the processor |
| rw_i | input | 1 | Bus direction: 1 = read, 0 = write |
| run_i | input | 1 | 1 = free run, 0 = step mode |
| instr_mode_i | input | 1 | Step granularity: 0 = bus cycle, 1 = instruction |
| step_btn_i | input | 1 | Raw, bouncing step push-button, active high |
| rdy_o | output | 1 | Ready line to the processor |
| halted_o | output | 1 | High while the processor is being held |

## Verification
The hardest case to reach is a halt that comes due on a write cycle and is then carried across further write cycles until a read arrives. Reaching it needs a step release to land just before a run of writes. The stimulus table gets there by pressing the button while halted and then driving two write cycles and a read. A second hard case is a press that is debounced while the processor is already running. The directed test gets there by releasing the processor in instruction granularity, holding it away from any fetch while a full second press completes, and then confirming that a later halt is not released.

// File: rtl/step_rdy_pkg.sv
package step_rdy_pkg;

  typedef enum logic {
    GRAN_CYCLE = 1'b0,
    GRAN_INSTR = 1'b1
  } step_gran_e;

  // one bus cycle as seen at the edge that closes it
  typedef struct packed {
    logic       run;
    step_gran_e gran;
    logic       fetch;
    logic       rd;
  } bus_view_t;

endpackage

// File: rtl/step_btn_sync.sv
module step_btn_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES:0]   shift_w;

  assign shift_w = {chain_q, d_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= shift_w[STAGES-1:0];
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/step_btn_debounce.sv
module step_btn_debounce #(
  parameter int unsigned HOLD_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic press_o
);

  localparam int unsigned CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic          stable_q, stable_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          press_q, press_d;

  always_comb begin
    stable_d = stable_q;
    cnt_d    = '0;
    press_d  = 1'b0;
    if (level_i != stable_q) begin
      if (cnt_q == LAST) begin
        stable_d = level_i;
        press_d  = level_i;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stable_q <= 1'b0;
      cnt_q    <= '0;
      press_q  <= 1'b0;
    end else begin
      stable_q <= stable_d;
      cnt_q    <= cnt_d;
      press_q  <= press_d;
    end
  end

  assign press_o = press_q;

endmodule

// File: rtl/step_halt_ctrl.sv
module step_halt_ctrl
  import step_rdy_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  bus_view_t bus_i,
  input  logic      step_i,
  output logic      rdy_o,
  output logic      boot_o,
  output logic      pend_o
);

  logic rdy_q, rdy_d;
  logic pend_q, pend_d;
  logic boot_q, boot_d;
  logic by_instr, halt_due;

  // until the first fetch after reset, stop only at a fetch
  assign by_instr = boot_q | (bus_i.gran == GRAN_INSTR);
  assign halt_due = pend_q | !by_instr | bus_i.fetch;

  always_comb begin
    rdy_d  = rdy_q;
    pend_d = pend_q;
    boot_d = boot_q;
    if (rdy_q && bus_i.fetch) boot_d = 1'b0;
    if (bus_i.run) begin
      rdy_d  = 1'b1;
      pend_d = 1'b0;
    end else if (!rdy_q) begin
      pend_d = 1'b0;
      if (step_i) rdy_d = 1'b1;
    end else if (halt_due) begin
      if (bus_i.rd) begin
        rdy_d  = 1'b0;
        pend_d = 1'b0;
      end else begin
        pend_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b1;
      pend_q <= 1'b0;
      boot_q <= 1'b1;
    end else begin
      rdy_q  <= rdy_d;
      pend_q <= pend_d;
      boot_q <= boot_d;
    end
  end

  assign rdy_o  = rdy_q;
  assign boot_o = boot_q;
  assign pend_o = pend_q;

endmodule

// File: rtl/step_rdy_ctrl.sv
module step_rdy_ctrl
  import step_rdy_pkg::*;
#(
  parameter int unsigned DEBOUNCE_CYCLES = 50000,
  parameter int unsigned SYNC_STAGES     = 2,
  parameter int unsigned RST_STAGES      = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic rw_i,
  input  logic run_i,
  input  logic instr_mode_i,
  input  logic step_btn_i,
  output logic rdy_o,
  output logic halted_o
);

  logic [RST_STAGES-1:0] rst_q;
  logic [RST_STAGES:0]   rst_shift;
  logic                  rst_core_n;
  logic                  btn_sync, step_pulse;
  logic                  rdy_w, boot_w, pend_w;
  bus_view_t             bus_w;

  // asynchronous assertion, synchronous release
  assign rst_shift = {rst_q, 1'b1};
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= rst_shift[RST_STAGES-1:0];
  end
  assign rst_core_n = rst_q[RST_STAGES-1];

  assign bus_w = '{run:   run_i,
                   gran:  step_gran_e'(instr_mode_i),
                   fetch: sync_i,
                   rd:    rw_i};

  step_btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_core_n),
    .d_i  (step_btn_i),
    .q_o  (btn_sync)
  );

  step_btn_debounce #(.HOLD_CYCLES(DEBOUNCE_CYCLES)) u_deb (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .level_i(btn_sync),
    .press_o(step_pulse)
  );

  step_halt_ctrl u_halt (
    .clk   (clk),
    .rst_n (rst_core_n),
    .bus_i (bus_w),
    .step_i(step_pulse),
    .rdy_o (rdy_w),
    .boot_o(boot_w),
    .pend_o(pend_w)
  );

  assign rdy_o    = rdy_w;
  assign halted_o = !rdy_w;

endmodule

// File: rtl/step_rdy_ctrl_chk.sv
module step_rdy_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic run_i,
  input logic instr_mode_i,
  input logic sync_i,
  input logic rw_i,
  input logic rdy_o,
  input logic halted_o,
  input logic boot,
  input logic pend
);

  assert_run_keeps_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |=> rdy_o);

  assert_halted_mirrors_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o != rdy_o);

  assert_cycle_mode_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !instr_mode_i && !boot && rdy_o && rw_i) |=> !rdy_o);

  assert_fetch_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && rdy_o && rw_i && sync_i) |=> !rdy_o);

  assert_instr_mode_passes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && instr_mode_i && rdy_o && !sync_i && !pend) |=> rdy_o);

  assert_write_never_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && rdy_o && !rw_i) |=> rdy_o);

  assert_boot_runs_to_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && boot && rdy_o && !sync_i) |=> rdy_o);

  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_ready_R6: assert (rdy_o);
    end
  end

endmodule

bind step_rdy_ctrl step_rdy_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .run_i       (run_i),
  .instr_mode_i(instr_mode_i),
  .sync_i      (sync_i),
  .rw_i        (rw_i),
  .rdy_o       (rdy_o),
  .halted_o    (halted_o),
  .boot        (boot_w),
  .pend        (pend_w)
);

// File: tb/step_rdy_ctrl_test.sv
module step_rdy_ctrl_test;

  localparam int unsigned DB = 8;
  localparam int NV = 20;

  // {press, run, instr, sync, rw, expected rdy after the cycle}
  localparam logic [5:0] VEC [0:NV-1] = '{
    6'b0_0_0_0_1_1,  // 0  R6 boot, read
    6'b0_0_0_0_0_1,  // 1  R6 boot, write
    6'b0_0_0_1_1_0,  // 2  R6 first fetch halts
    6'b0_0_0_0_1_0,  // 3  R3 stays halted
    6'b1_0_0_0_1_1,  // 4  R8 press
    6'b0_0_0_0_1_0,  // 5  R3 one cycle released
    6'b0_0_0_0_1_0,  // 6  R8 held button, no more
    6'b1_0_0_0_1_1,  // 7  R8 press
    6'b0_0_0_0_0_1,  // 8  R5 write defers
    6'b0_0_0_0_0_1,  // 9  R5 still write
    6'b0_0_0_0_1_0,  // 10 R5 read takes halt
    6'b1_0_1_0_1_1,  // 11 R8 press, instr mode
    6'b0_0_1_0_1_1,  // 12 R4 operand passes
    6'b0_0_1_0_0_1,  // 13 R4 data write passes
    6'b0_0_1_0_1_1,  // 14 R4 read passes
    6'b0_0_1_1_1_0,  // 15 R4 fetch halts
    6'b0_1_1_0_1_1,  // 16 R10 run raises
    6'b0_1_1_1_1_1,  // 17 R1 run ignores fetch
    6'b0_1_0_1_0_1,  // 18 R1 run
    6'b0_0_0_0_1_0   // 19 R10 step cycle halts
  };

  logic clk = 1'b0;
  logic rst_n, sync_i, rw_i, run_i, instr_mode_i, step_btn_i;
  logic rdy_o, halted_o;
  int   n_checks = 0;
  int   n_fail   = 0;
  int   cyc      = 0;
  bit   done     = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  step_rdy_ctrl #(.DEBOUNCE_CYCLES(DB)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_i      (sync_i),
    .rw_i        (rw_i),
    .run_i       (run_i),
    .instr_mode_i(instr_mode_i),
    .step_btn_i  (step_btn_i),
    .rdy_o       (rdy_o),
    .halted_o    (halted_o)
  );

  function automatic string row_tag(int i);
    case (i)
      0, 1, 2:        return "R6";
      3, 5:           return "R3";
      4, 6, 7, 11:    return "R8";
      8, 9, 10:       return "R5";
      12, 13, 14, 15: return "R4";
      17, 18:         return "R1";
      default:        return "R10";
    endcase
  endfunction

  task automatic check(string tag, logic exp_rdy);
    n_checks++;
    if (rdy_o !== exp_rdy || halted_o !== !exp_rdy) begin
      n_fail++;
      $display("FAIL %s: rdy=%b halted=%b, expected rdy=%b halted=%b",
               tag, rdy_o, halted_o, exp_rdy, !exp_rdy);
    end
  endtask

  // one bus cycle: inputs set at negedge, result sampled at next negedge
  task automatic bus_cycle(logic s, logic r);
    sync_i = s;
    rw_i   = r;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) bus_cycle(1'b0, 1'b1);
  endtask

  task automatic press(string tag);
    step_btn_i = 1'b0;
    idle(DB + 4);
    step_btn_i = 1'b1;
    for (int k = 0; k < 40 && !rdy_o; k++) bus_cycle(1'b0, 1'b1);
    check(tag, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; sync_i = 1'b0; rw_i = 1'b1;
    run_i = 1'b0; instr_mode_i = 1'b0; step_btn_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R6 reset state", 1'b1);
    rst_n = 1'b1;
    idle(3);

    for (int i = 0; i < NV; i++) begin
      run_i        = VEC[i][4];
      instr_mode_i = VEC[i][3];
      if (VEC[i][5]) press(row_tag(i));
      else begin
        bus_cycle(VEC[i][2], VEC[i][1]);
        check(row_tag(i), VEC[i][0]);
      end
    end

    // R9: a press completing while running is discarded
    instr_mode_i = 1'b1;
    press("R9 release");
    step_btn_i = 1'b0;
    idle(DB + 6);
    step_btn_i = 1'b1;
    idle(DB + 10);
    check("R9 running press no effect", 1'b1);
    bus_cycle(1'b1, 1'b1);
    check("R9 fetch halts", 1'b0);
    idle(20);
    check("R9 press not stored", 1'b0);

    // R7: a bounce shorter than the debounce window releases nothing
    step_btn_i = 1'b0;
    idle(DB + 6);
    step_btn_i = 1'b1;
    idle(3);
    step_btn_i = 1'b0;
    idle(DB + 20);
    check("R7 short pulse ignored", 1'b0);
    press("R7 full press");

    // R6: reset while halted, then step mode boot runs to first fetch
    instr_mode_i = 1'b0;
    bus_cycle(1'b0, 1'b1);
    check("R3 cycle halt before reset", 1'b0);
    #1 rst_n = 1'b0;
    #1 check("R6 reset forces ready", 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    idle(5);
    check("R6 boot ignores cycle mode", 1'b1);
    bus_cycle(1'b1, 1'b1);
    check("R6 halt at first fetch", 1'b0);

    done = 1'b1;
  end

  initial begin
    wait (done || cyc > 20000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: cycles=%0d, expected completion", cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule